// File: doc/BRIEF.md
# Segment LCD Correlation Drive Sequencer

This block produces the digital common (COM) and segment drive signals for a multiplexed segment LCD run in digital correlation mode. A frame is built from subframes, one per addressed common; each subframe splits into four quarters whose length comes from a programmable clock divider. An optional idle gap of programmable length follows every frame. In single-pass addressing each active common is selected once per frame. In double-pass addressing it is selected twice in a row, the second time with inverted polarity, so that the pair carries no DC.

Display contents sit in four data groups, one per set of four commons. A simple write port loads 32-bit words into them. The configuration inputs and the display contents are sampled only when a frame begins, so a running frame always completes with the settings it started with. Analog bias levels, the bus interface and clock selection are outside this block.

Top module: `lcd_corr_drive`

## Requirements
- R1: Each quarter-subframe lasts `cfg_subfr_div`+1 input clock cycles, so a subframe lasts 4×(`cfg_subfr_div`+1) cycles.
- R2: After the last subframe of a frame, every COM and segment output is held low for `cfg_dead_len` cycles. A value of 0 inserts no gap, and the next frame starts on the following cycle.
- R3: The number of active commons is `cfg_com_sel`+2 (2 to 16). Code 15 is treated as 16 commons. Commons at or above the active count stay low while the block is running.
- R4: With `cfg_type_b`=0, commons are selected once each in ascending order from COM 0. Over its four quarters the selected common drives 0,1,0,1, and every other active common drives the inverse.
- R5: With `cfg_type_b`=1, each common is selected for two consecutive subframes. The first subframe drives 0,1,0,1 and the second drives 1,0,1,0, and all other active commons drive the inverse in both.
- R6: Segment output i equals the selected common's level XOR the data bit for pin i and the selected common c. That bit sits in group c/4, word i/8, bit 4×(i mod 8)+(c mod 4).
- R7: Configuration inputs and data-word writes made during a frame take effect only at the start of the next frame.
- R8: While `en` is low, all outputs are low. After `en` is sampled high, the first frame starts on the next cycle, at COM 0, quarter 0, first pass.
- R9: After reset all outputs are low and every data word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Sequencer enable |
| cfg_subfr_div | input | DIV_W | Quarter-subframe divide value minus one |
| cfg_dead_len | input | DEAD_W | Idle gap length in cycles after each frame |
| cfg_com_sel | input | 4 | Active common count minus two |
| cfg_type_b | input | 1 | 1 selects double-pass balanced addressing |
| wr_en | input | 1 | Data word write strobe |
| wr_bank | input | 2 | Common group of the written word |
| wr_word | input | WSEL_W | Pin word index (pins 8w to 8w+7) |
| wr_data | input | 32 | Data word, four bits per pin |
| com_out | output | 16 | Common drive levels |
| seg_out | output | NUM_PINS | Segment drive levels |

## Verification
The assertions check on every cycle that outputs are quiet while the block is disabled or in the gap, and that a running frame shows exactly one common out of phase with the others. They also check that commons above the active count stay low, that the quarter index moves only on a divider tick, and that the latched configuration does not change within a frame. Quarter lengths, the common ordering, the polarity of each pass, the segment data mapping and the deferral of mid-frame changes to the next frame are shown only by the bench. It sweeps divider values, gap lengths, common counts and both addressing schemes, and compares every output cycle against an arithmetic model.

// File: rtl/lcdseq_pkg.sv
// Shared constants, state encoding and helpers for the LCD drive sequencer.
// Assumes at most 16 commons, grouped four to a data group.
package lcdseq_pkg;
    localparam int COM_MAX       = 16;
    localparam int GROUPS        = 4;
    localparam int PINS_PER_WORD = 8;
    localparam int WORD_W        = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_e;

    // Active common count from the select code; code 15 is clamped to 16.
    function automatic logic [4:0] com_count(input logic [3:0] sel);
        return (sel == 4'd15) ? 5'd16 : ({1'b0, sel} + 5'd2);
    endfunction
endpackage

// File: rtl/lcdseq_divider.sv
// Quarter-subframe divider: pulses tick every DIV+1 cycles while run is high.
// Assumes div is stable within a frame (it comes from the latched config).
module lcdseq_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = 1;

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    // Count cycles within a quarter; clear when stopped or on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + ONE;
    end
endmodule

// File: rtl/lcdseq_ctrl.sv
// Frame sequencer: walks quarters, passes and commons, inserts the idle gap,
// and latches the configuration at every frame start.
// Assumes tick comes from a divider driven by sh_div and run_st.
module lcdseq_ctrl #(
    parameter int DIV_W  = 16,
    parameter int DEAD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DIV_W-1:0]  cfg_subfr_div,
    input  logic [DEAD_W-1:0] cfg_dead_len,
    input  logic [3:0]        cfg_com_sel,
    input  logic              cfg_type_b,
    input  logic              tick,
    output logic              run_st,
    output logic              gap_st,
    output logic              frm_load,
    output logic [1:0]        qtr_idx,
    output logic [3:0]        com_idx,
    output logic              pass_neg,
    output logic [DIV_W-1:0]  sh_div,
    output logic [4:0]        sh_com_n,
    output logic              sh_type_b
);
    import lcdseq_pkg::*;

    localparam logic [DEAD_W-1:0] GAP_ONE = 1;

    seq_state_e        state;
    logic [DEAD_W-1:0] gap_cnt;
    logic [DEAD_W-1:0] sh_dead;
    logic              last_pass;
    logic              last_com;
    logic              frame_end;
    logic              gap_end;

    assign run_st    = (state == ST_RUN);
    assign gap_st    = (state == ST_GAP);
    assign last_pass = (pass_neg == sh_type_b);
    assign last_com  = ({1'b0, com_idx} == (sh_com_n - 5'd1));
    assign frame_end = run_st && tick && (qtr_idx == 2'd3) && last_pass && last_com;
    assign gap_end   = gap_st && (gap_cnt == (sh_dead - GAP_ONE));
    assign frm_load  = en && ((state == ST_IDLE) ||
                              (frame_end && (sh_dead == '0)) ||
                              gap_end);

    // Advance state and position counters.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state    <= ST_IDLE;
            qtr_idx  <= 2'd0;
            com_idx  <= 4'd0;
            pass_neg <= 1'b0;
            gap_cnt  <= '0;
        end else if (frm_load) begin
            state    <= ST_RUN;
            qtr_idx  <= 2'd0;
            com_idx  <= 4'd0;
            pass_neg <= 1'b0;
            gap_cnt  <= '0;
        end else if (frame_end) begin
            state    <= ST_GAP;
            qtr_idx  <= 2'd0;
            com_idx  <= 4'd0;
            pass_neg <= 1'b0;
            gap_cnt  <= '0;
        end else if (gap_st) begin
            gap_cnt  <= gap_cnt + GAP_ONE;
        end else if (run_st && tick) begin
            qtr_idx <= qtr_idx + 2'd1;
            if (qtr_idx == 2'd3) begin
                if (!last_pass) begin
                    pass_neg <= 1'b1;
                end else begin
                    pass_neg <= 1'b0;
                    com_idx  <= com_idx + 4'd1;
                end
            end
        end
    end

    // Latch the frame configuration at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_div    <= '0;
            sh_dead   <= '0;
            sh_com_n  <= 5'd2;
            sh_type_b <= 1'b0;
        end else if (frm_load) begin
            sh_div    <= cfg_subfr_div;
            sh_dead   <= cfg_dead_len;
            sh_com_n  <= com_count(cfg_com_sel);
            sh_type_b <= cfg_type_b;
        end
    end
endmodule

// File: rtl/lcdseq_bank.sv
// Display data store: write-side words plus a frame copy taken at frame start.
// Assumes wr_word indices at or above WORDS are dropped.
module lcdseq_bank #(
    parameter int WORDS  = 2,
    parameter int WSEL_W = 1
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          wr_en,
    input  logic [1:0]                                    wr_bank,
    input  logic [WSEL_W-1:0]                             wr_word,
    input  logic [31:0]                                   wr_data,
    input  logic                                          frm_load,
    output logic [lcdseq_pkg::GROUPS-1:0][WORDS-1:0][31:0] frame_data
);
    import lcdseq_pkg::*;

    logic [GROUPS-1:0][WORDS-1:0][31:0] live;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            // Accept a write addressed to this group and word.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    live[g][w] <= '0;
                else if (wr_en && (wr_bank == 2'(g)) && (wr_word == WSEL_W'(w)))
                    live[g][w] <= wr_data;
            end

            // Copy the word into the frame image at frame start.
            always_ff @(posedge clk) begin
                if (!rst_n)        frame_data[g][w] <= '0;
                else if (frm_load) frame_data[g][w] <= live[g][w];
            end
        end
    end
endmodule

// File: rtl/lcdseq_drive.sv
// Output decode: forms common and segment levels from the sequencer position
// and the frame data image. Outputs are low outside the run state.
module lcdseq_drive #(
    parameter int NUM_PINS = 16,
    parameter int WORDS    = 2
) (
    input  logic                                          run_st,
    input  logic [1:0]                                    qtr_idx,
    input  logic [3:0]                                    com_idx,
    input  logic                                          pass_neg,
    input  logic [4:0]                                    sh_com_n,
    input  logic [lcdseq_pkg::GROUPS-1:0][WORDS-1:0][31:0] frame_data,
    output logic [lcdseq_pkg::COM_MAX-1:0]                com_out,
    output logic [NUM_PINS-1:0]                           seg_out
);
    import lcdseq_pkg::*;

    logic                     phase;
    logic [WORDS-1:0][31:0]   grp_words;

    assign phase     = qtr_idx[0] ^ pass_neg;
    assign grp_words = frame_data[com_idx[3:2]];

    for (genvar k = 0; k < COM_MAX; k++) begin : g_com
        assign com_out[k] = run_st && (5'(k) < sh_com_n) &&
                            ((4'(k) == com_idx) ? phase : !phase);
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam int WI = i / PINS_PER_WORD;
        localparam int BI = 4 * (i % PINS_PER_WORD);
        logic [3:0] nib;
        assign nib        = grp_words[WI][BI +: 4];
        assign seg_out[i] = run_st && (phase ^ nib[com_idx[1:0]]);
    end
endmodule

// File: rtl/lcd_corr_drive.sv
// Top level of the segment LCD correlation drive sequencer: divider,
// frame sequencer, data store and output decode.
// Assumes configuration inputs are in the clk domain.
module lcd_corr_drive #(
    parameter int NUM_PINS = 16,
    parameter int DIV_W    = 16,
    parameter int DEAD_W   = 16,
    parameter int WORDS    = (NUM_PINS + lcdseq_pkg::PINS_PER_WORD - 1) / lcdseq_pkg::PINS_PER_WORD,
    parameter int WSEL_W   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [DIV_W-1:0]    cfg_subfr_div,
    input  logic [DEAD_W-1:0]   cfg_dead_len,
    input  logic [3:0]          cfg_com_sel,
    input  logic                cfg_type_b,
    input  logic                wr_en,
    input  logic [1:0]          wr_bank,
    input  logic [WSEL_W-1:0]   wr_word,
    input  logic [31:0]         wr_data,
    output logic [15:0]         com_out,
    output logic [NUM_PINS-1:0] seg_out
);
    import lcdseq_pkg::*;

    logic                               qtr_tick;
    logic                               st_run;
    logic                               st_gap;
    logic                               frm_load;
    logic [1:0]                         qtr_idx;
    logic [3:0]                         com_idx;
    logic                               pass_neg;
    logic [DIV_W-1:0]                   sh_div;
    logic [4:0]                         sh_com_n;
    logic                               sh_type_b;
    logic [GROUPS-1:0][WORDS-1:0][31:0] frame_data;

    lcdseq_divider #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st_run),
        .div  (sh_div),
        .tick (qtr_tick)
    );

    lcdseq_ctrl #(.DIV_W(DIV_W), .DEAD_W(DEAD_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .cfg_subfr_div(cfg_subfr_div),
        .cfg_dead_len (cfg_dead_len),
        .cfg_com_sel  (cfg_com_sel),
        .cfg_type_b   (cfg_type_b),
        .tick         (qtr_tick),
        .run_st       (st_run),
        .gap_st       (st_gap),
        .frm_load     (frm_load),
        .qtr_idx      (qtr_idx),
        .com_idx      (com_idx),
        .pass_neg     (pass_neg),
        .sh_div       (sh_div),
        .sh_com_n     (sh_com_n),
        .sh_type_b    (sh_type_b)
    );

    lcdseq_bank #(.WORDS(WORDS), .WSEL_W(WSEL_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_bank   (wr_bank),
        .wr_word   (wr_word),
        .wr_data   (wr_data),
        .frm_load  (frm_load),
        .frame_data(frame_data)
    );

    lcdseq_drive #(.NUM_PINS(NUM_PINS), .WORDS(WORDS)) u_drive (
        .run_st    (st_run),
        .qtr_idx   (qtr_idx),
        .com_idx   (com_idx),
        .pass_neg  (pass_neg),
        .sh_com_n  (sh_com_n),
        .frame_data(frame_data),
        .com_out   (com_out),
        .seg_out   (seg_out)
    );
endmodule

// File: rtl/lcd_corr_drive_chk.sv
// Property checker for lcd_corr_drive, attached by bind below.
module lcd_corr_drive_chk #(
    parameter int NUM_PINS = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                en,
    input logic [15:0]         com_out,
    input logic [NUM_PINS-1:0] seg_out,
    input logic                st_run,
    input logic                st_gap,
    input logic                frm_load,
    input logic                qtr_tick,
    input logic [1:0]          qtr_idx,
    input logic [3:0]          com_idx,
    input logic                pass_neg,
    input logic [4:0]          sh_com_n,
    input logic                sh_type_b
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (com_out == '0 && seg_out == '0)); // R8
    AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        st_gap |-> (com_out == '0 && seg_out == '0)); // R2
    AST_ONE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        st_run |-> ($countones(com_out) == 1 ||
                    $countones(com_out) == 32'(sh_com_n) - 1)); // R4
    AST_UNUSED_COMS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_run |-> ((com_out >> sh_com_n) == '0)); // R3
    AST_COM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_run |-> ({1'b0, com_idx} < sh_com_n)); // R3
    AST_QTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_run && !qtr_tick && en) |=> $stable(qtr_idx)); // R1
    AST_SINGLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_run && !sh_type_b) |-> !pass_neg); // R4
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_run && !frm_load && en) |=> ($stable(sh_com_n) && $stable(sh_type_b))); // R7
endmodule

bind lcd_corr_drive lcd_corr_drive_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .com_out  (com_out),
    .seg_out  (seg_out),
    .st_run   (st_run),
    .st_gap   (st_gap),
    .frm_load (frm_load),
    .qtr_tick (qtr_tick),
    .qtr_idx  (qtr_idx),
    .com_idx  (com_idx),
    .pass_neg (pass_neg),
    .sh_com_n (sh_com_n),
    .sh_type_b(sh_type_b)
);

// File: tb/lcd_corr_drive_test.sv
module lcd_corr_drive_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        en;
    logic [15:0] cfg_subfr_div;
    logic [15:0] cfg_dead_len;
    logic [3:0]  cfg_com_sel;
    logic        cfg_type_b;
    logic        wr_en;
    logic [1:0]  wr_bank;
    logic [0:0]  wr_word;
    logic [31:0] wr_data;
    logic [15:0] com_out;
    logic [15:0] seg_out;

    int n_run  = 0;
    int n_fail = 0;
    logic [31:0] img [4][2];

    lcd_corr_drive uut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .cfg_subfr_div(cfg_subfr_div), .cfg_dead_len(cfg_dead_len),
        .cfg_com_sel(cfg_com_sel), .cfg_type_b(cfg_type_b),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_word(wr_word), .wr_data(wr_data),
        .com_out(com_out), .seg_out(seg_out)
    );

    always #10 clk = ~clk;

    task automatic check(string tag, logic [15:0] ec, logic [15:0] es);
        n_run++;
        if (com_out !== ec || seg_out !== es) begin
            n_fail++;
            $display("FAIL %s: com=%h seg=%h expected com=%h seg=%h",
                     tag, com_out, seg_out, ec, es);
        end
    endtask

    task automatic wr(int b, int w, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_bank = 2'(b); wr_word = 1'(w); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        img[b][w] = d;
    endtask

    // Walk nfr frames against the arithmetic model; optional mid-frame poke
    // of config and data, optional early stop after a cycle count.
    task automatic run(int nfr, string tag, int poke, int stop);
        int cyc = 0;
        for (int f = 0; f < nfr; f++) begin
            int m_div  = int'(cfg_subfr_div);
            int m_dead = int'(cfg_dead_len);
            int m_n    = (cfg_com_sel == 4'd15) ? 16 : int'(cfg_com_sel) + 2;
            int m_p    = cfg_type_b ? 2 : 1;
            int d      = m_div + 1;
            int len    = m_n * m_p * 4 * d;
            logic [31:0] mimg [4][2];
            for (int b = 0; b < 4; b++)
                for (int w = 0; w < 2; w++) mimg[b][w] = img[b][w];
            for (int t = 0; t < len + m_dead; t++) begin
                logic [15:0] ec = '0;
                logic [15:0] es = '0;
                string tg = tag;
                if (stop >= 0 && cyc == stop) return;
                @(negedge clk);
                cyc++;
                if (t < len) begin
                    int sub = t / (4 * d);
                    int c   = sub / m_p;
                    int p   = sub % m_p;
                    int q   = (t / d) % 4;
                    logic ph = logic'((q % 2) ^ p);
                    for (int k = 0; k < m_n; k++) ec[k] = (k == c) ? ph : !ph;
                    for (int i = 0; i < 16; i++)
                        es[i] = ph ^ mimg[c / 4][i / 8][4 * (i % 8) + c % 4];
                end else begin
                    tg = "R2";
                end
                check(tg, ec, es);
                if (f == 0 && t == poke) begin
                    cfg_subfr_div = 16'd1; cfg_com_sel = 4'd3;
                    cfg_type_b = 1'b1; cfg_dead_len = 16'd0;
                    wr_en = 1'b1; wr_bank = 2'd1; wr_word = 1'b1;
                    wr_data = 32'h0F0F_3C3C;
                    img[1][1] = 32'h0F0F_3C3C;
                end
                if (f == 0 && t == poke + 1) wr_en = 1'b0;
            end
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        int sels [4] = '{0, 2, 13, 15};
        int deads [2] = '{0, 3};
        rst_n = 1'b0; en = 1'b0; wr_en = 1'b0; wr_bank = '0; wr_word = '0;
        wr_data = '0; cfg_subfr_div = '0; cfg_dead_len = '0;
        cfg_com_sel = '0; cfg_type_b = 1'b0;
        for (int b = 0; b < 4; b++)
            for (int w = 0; w < 2; w++) img[b][w] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9", 16'h0, 16'h0);
        rst_n = 1'b1;

        // R9: data cleared by reset, so segments follow the common phase.
        en = 1'b1;
        run(1, "R9", -1, -1);
        en = 1'b0;
        @(negedge clk);
        check("R8", 16'h0, 16'h0);

        for (int b = 0; b < 4; b++)
            for (int w = 0; w < 2; w++)
                wr(b, w, 32'h9E37_79B9 * (b * 2 + w + 1) ^ (32'h1234_5678 >> b));

        // Sweep of divider, gap, common count and addressing scheme.
        for (int dv = 0; dv < 3; dv++)
            for (int di = 0; di < 2; di++)
                for (int si = 0; si < 4; si++)
                    for (int tb = 0; tb < 2; tb++) begin
                        string base;
                        en = 1'b0;
                        cfg_subfr_div = 16'(dv); cfg_dead_len = 16'(deads[di]);
                        cfg_com_sel = 4'(sels[si]); cfg_type_b = 1'(tb);
                        @(negedge clk);
                        @(negedge clk);
                        if (sels[si] == 15)  base = "R3";
                        else if (dv == 2)    base = "R1";
                        else if (tb == 1)    base = "R5";
                        else                 base = "R4";
                        en = 1'b1;
                        run(2, $sformatf("%s/R6", base), -1, -1);
                    end

        // R8: disable mid-frame, outputs low, restart from the first common.
        en = 1'b0;
        cfg_subfr_div = 16'd1; cfg_dead_len = 16'd2;
        cfg_com_sel = 4'd4; cfg_type_b = 1'b1;
        @(negedge clk);
        en = 1'b1;
        run(1, "R8", -1, 40);
        en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R8", 16'h0, 16'h0);
        end
        en = 1'b1;
        run(1, "R8", -1, -1);

        // R7: mid-frame config and data changes wait for the next frame.
        en = 1'b0;
        cfg_subfr_div = 16'd0; cfg_dead_len = 16'd2;
        cfg_com_sel = 4'd1; cfg_type_b = 1'b0;
        @(negedge clk);
        @(negedge clk);
        en = 1'b1;
        run(2, "R7", 5, -1);

        summary();
        $finish;
    end
endmodule